// File: doc/BRIEF.md
# SPI Flash Status Register Controller

This block is the slave-side control logic of a serial flash for its status byte. It watches a mode-0 SPI link (active-low select, clock, data in), brings those pins into the system clock domain, and decodes three one-byte commands. The first command arms a write-enable latch. The second returns the status byte on the data-out pin. The third loads a new status value.

An accepted status load starts a self-timed busy period that is counted in system clocks. The status byte can still be read while that period runs. A sticky write-disable bit works together with an active-low write-protect pin to lock the status byte in hardware. The three block-protect bits leave the block on a separate output, where array-protection logic elsewhere can use them.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `prot` is 0 and `miso` is high impedance.
- R2: A frame holding exactly the 8 bits 06h sets the write-enable latch, which is status bit 1.
- R3: Opcode 05h returns the status byte on `miso`, MSB first. Each bit changes after a falling `sck` and is valid at the next rising edge. The byte repeats for as long as `cs_n` stays low, and `miso` is high impedance whenever no read is active.
- R4: A frame of exactly 16 bits, made of opcode 01h and then a data byte, copies data bit 7 into the write-disable bit (status bit 7) and data bits 4:2 into the block-protect bits (status bits 4:2). Status bits 6 and 5 always read 0. Data bits 1 and 0 have no effect.
- R5: A status load is ignored when the write-enable latch is clear.
- R6: A status load whose frame ends after any bit count other than 16 is ignored, and the write-enable latch stays set.
- R7: An accepted load sets the busy flag (status bit 0) for WR_CYCLES system clocks. While the flag is set the status byte can be read. When the flag clears, the write-enable latch clears with it.
- R8: While the busy flag is set, every command except the status read is ignored.
- R9: When the write-disable bit is 1 and `wp_n` is 0, status loads are ignored. With `wp_n` at 1 they are accepted.
- R10: `prot` always equals status bits 4:2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out, high impedance when not reading |
| prot | output | 3 | Block-protect bits for array-protection logic |

## Verification
The assertions assume that every SPI pin holds each level for several system clocks, so the synchronizer never misses an edge. They also assume that `wp_n` is steady around the rise of `cs_n`. The bench keeps to both. It uses SPI half-periods of five system clocks, waits ten clocks after each deselect, and changes `wp_n` only while the link is idle. Frames that are too short or too long are sent on purpose, so the bit-count rule is exercised at the ports.

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       wp_n,
  output logic       miso,
  output logic [2:0] prot
);

  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  logic [SYNC_STAGES-1:0] cs_sy, sck_sy, di_sy, wp_sy;
  logic s_cs, s_sck, s_di, s_wp;
  logic cs_d, sck_d;
  logic cs_rise, sck_rise, sck_fall;

  logic [4:0]    bit_cnt;
  logic [7:0]    shreg, opcode, rd_snap;
  logic [7:0]    nxt_byte;
  logic          rd_mode, rd_act, miso_q;
  logic [2:0]    rd_idx;
  logic          srwd, wel, wip;
  logic [2:0]    bp;
  logic [CW-1:0] busy_cnt;
  logic [7:0]    status;

  assign s_cs  = cs_sy[SYNC_STAGES-1];
  assign s_sck = sck_sy[SYNC_STAGES-1];
  assign s_di  = di_sy[SYNC_STAGES-1];
  assign s_wp  = wp_sy[SYNC_STAGES-1];

  assign cs_rise  = s_cs & ~cs_d;
  assign sck_rise = ~s_cs & s_sck & ~sck_d;
  assign sck_fall = ~s_cs & ~s_sck & sck_d;

  assign nxt_byte = {shreg[6:0], s_di};
  assign status   = {srwd, 2'b00, bp, wel, wip};
  assign prot     = bp;
  assign miso     = rd_act ? miso_q : 1'bz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= '1;
      sck_sy <= '0;
      di_sy  <= '0;
      wp_sy  <= '1;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      di_sy  <= {di_sy[SYNC_STAGES-2:0], mosi};
      wp_sy  <= {wp_sy[SYNC_STAGES-2:0], wp_n};
      cs_d   <= s_cs;
      sck_d  <= s_sck;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      opcode  <= '0;
      rd_mode <= 1'b0;
      rd_act  <= 1'b0;
      rd_idx  <= '0;
      rd_snap <= '0;
      miso_q  <= 1'b0;
    end else if (s_cs) begin
      bit_cnt <= '0;
      rd_mode <= 1'b0;
      rd_act  <= 1'b0;
      rd_idx  <= '0;
    end else begin
      if (sck_rise) begin
        shreg <= nxt_byte;
        if (bit_cnt != 5'd31) bit_cnt <= bit_cnt + 5'd1;
        if (bit_cnt == 5'd7) begin
          opcode  <= nxt_byte;
          rd_mode <= (nxt_byte == OP_RDSR);
        end
      end
      if (sck_fall && rd_mode) begin
        rd_act <= 1'b1;
        rd_idx <= rd_idx + 3'd1;
        if (rd_idx == 3'd0) begin
          rd_snap <= status;
          miso_q  <= status[7];
        end else begin
          miso_q  <= rd_snap[3'd7 - rd_idx];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd     <= 1'b0;
      bp       <= '0;
      wel      <= 1'b0;
      wip      <= 1'b0;
      busy_cnt <= '0;
    end else if (wip) begin
      if (busy_cnt == '0) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end else begin
        busy_cnt <= busy_cnt - 1'b1;
      end
    end else if (cs_rise) begin
      if (bit_cnt == 5'd8 && opcode == OP_WREN) begin
        wel <= 1'b1;
      end else if (bit_cnt == 5'd16 && opcode == OP_WRSR && wel && !(srwd && !s_wp)) begin
        srwd     <= shreg[7];
        bp       <= shreg[4:2];
        wip      <= 1'b1;
        busy_cnt <= CW'(WR_CYCLES - 1);
      end
    end
  end

endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_cs,
  input logic       cs_rise,
  input logic       s_wp,
  input logic       srwd,
  input logic       wel,
  input logic       wip,
  input logic       rd_act,
  input logic [2:0] prot
);

  AST_BUSY_HOLDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> wel); // R7

  AST_BUSY_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel); // R7

  AST_PROT_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot) |-> $rose(wip)); // R4

  AST_BUSY_FREEZES_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> $stable(prot)); // R8

  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && srwd && !s_wp) |=> !$rose(wip)); // R9

  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> !rd_act); // R3

endmodule

bind spi_status_ctrl spi_status_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .s_cs(s_cs), .cs_rise(cs_rise), .s_wp(s_wp),
  .srwd(srwd), .wel(wel), .wip(wip), .rd_act(rd_act), .prot(prot)
);

// File: tb/test_spi_status_ctrl.sv
module test_spi_status_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  wire  miso;
  wire [2:0] prot;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_status_ctrl #(.WR_CYCLES(400)) i_spi_status_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .prot(prot)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0; mosi = v[i]; #50;
      sck = 1'b1; #50;
    end
    sck = 1'b0;
  endtask

  task automatic frame(input int n, input logic [31:0] v);
    cs_n = 1'b0; #50;
    shift_bits(n, v);
    #50 cs_n = 1'b1; #100;
  endtask

  task automatic read_status(input int nbytes, output logic [15:0] got);
    got = '0;
    cs_n = 1'b0; #50;
    shift_bits(8, 32'h05);
    for (int i = 0; i < nbytes * 8; i++) begin
      sck = 1'b0; mosi = 1'b0; #50;
      got = {got[14:0], miso};
      sck = 1'b1; #50;
    end
    sck = 1'b0; #50 cs_n = 1'b1; #100;
  endtask

  task automatic wait_idle();
    #5000;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    check("R1 miso idle", {7'b0, miso}, {7'b0, 1'bz});
    check("R1 prot", {5'b0, prot}, 8'h00);
    read_status(1, r);
    check("R1 status", r[7:0], 8'h00);
    check("R3 z after read", {7'b0, miso}, {7'b0, 1'bz});
  endtask

  task automatic t_wren_and_write();
    logic [15:0] r;
    frame(8, 32'h06);
    read_status(1, r);
    check("R2 wel set", r[7:0], 8'h02);
    frame(16, 32'h01FF);
    read_status(1, r);
    check("R7 busy readable", r[7:0], 8'h9F);
    read_status(1, r);
    check("R7 still busy", r[7:0], 8'h9F);
    wait_idle();
    read_status(1, r);
    check("R4 R7 after cycle", r[7:0], 8'h9C);
    check("R10 prot", {5'b0, prot}, 8'h07);
  endtask

  task automatic t_no_wel();
    logic [15:0] r;
    frame(16, 32'h0100);
    wait_idle();
    read_status(1, r);
    check("R5 ignored w/o wel", r[7:0], 8'h9C);
  endtask

  task automatic t_bad_length();
    logic [15:0] r;
    frame(8, 32'h06);
    frame(15, 32'h0080);
    wait_idle();
    read_status(1, r);
    check("R6 15 bits", r[7:0], 8'h9E);
    frame(17, 32'h00200);
    wait_idle();
    read_status(1, r);
    check("R6 17 bits", r[7:0], 8'h9E);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] r;
    frame(16, 32'h0100);
    frame(16, 32'h019C);
    frame(8, 32'h06);
    wait_idle();
    read_status(1, r);
    check("R8 busy ignores cmds", r[7:0], 8'h00);
    check("R10 prot clear", {5'b0, prot}, 8'h00);
  endtask

  task automatic t_hw_lock();
    logic [15:0] r;
    frame(8, 32'h06);
    frame(16, 32'h0180);
    wait_idle();
    read_status(1, r);
    check("R4 srwd set", r[7:0], 8'h80);
    wp_n = 1'b0; #100;
    frame(8, 32'h06);
    frame(16, 32'h010C);
    wait_idle();
    read_status(1, r);
    check("R9 locked", r[7:0], 8'h82);
    check("R9 prot kept", {5'b0, prot}, 8'h00);
    wp_n = 1'b1; #100;
    frame(16, 32'h010C);
    wait_idle();
    read_status(1, r);
    check("R9 unlocked", r[7:0], 8'h0C);
    check("R10 prot", {5'b0, prot}, 8'h03);
  endtask

  task automatic t_repeat_read();
    logic [15:0] r;
    read_status(2, r);
    check("R3 first byte", r[15:8], 8'h0C);
    check("R3 repeated byte", r[7:0], 8'h0C);
    check("R3 z idle", {7'b0, miso}, {7'b0, 1'bz});
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100 rst_n = 1'b1;
    #100;
    t_reset();
    t_wren_and_write();
    t_no_wel();
    t_bad_length();
    t_busy_ignore();
    t_hw_lock();
    t_repeat_read();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule